// File: doc/BRIEF.md
# Dual-Mode FIFO Read Controller

This block is a single-clock FIFO whose read side works in one of two timing modes, chosen by a strap input while master reset is held. In standard mode a word is delivered only after a read request, and the two status outputs mean "empty" and "full". In fall-through mode the head of the queue is pushed to the output on its own, and the same two outputs mean "output ready" and "input ready". A half-full flag works in both modes.

Two extra controls act on the pointers. Partial reset empties the queue but keeps the selected mode. Retransmit rewinds the read side to the first memory location so that stored data can be replayed. Depth must be a power of two. Read enable, write enable and retransmit are active low.

Top module: `ff_dm_ctrl`

## Requirements
- R1: `mode_sel_i` is captured only in a cycle with `mrst_i` high (0 = standard, 1 = fall-through). The mode holds through `prst_i` and through normal operation.
- R2: In standard mode, a clock edge with `ren_ni` low and a non-empty memory puts the oldest word on `dout_o` after that edge. Words come out in write order.
- R3: In standard mode, `out_flag_o` is 1 when the memory holds no word, and `in_flag_o` is 1 when it holds DEPTH words.
- R4: In fall-through mode, a word written into an empty FIFO appears on `dout_o`, with `out_flag_o` rising, after the third rising edge counted from the write edge. No read request is needed.
- R5: In fall-through mode, `dout_o` and `out_flag_o` hold while `ren_ni` is high. An edge with `ren_ni` low and `out_flag_o` high advances to the next word, or drops `out_flag_o` if none is left.
- R6: In fall-through mode, `out_flag_o` is 1 while a word is presented. `in_flag_o` is 1 while the memory array holds fewer than DEPTH words.
- R7: `half_o` is 1 when the memory array holds more than DEPTH/2 words.
- R8: A write is dropped when the memory holds DEPTH words. A read is dropped when no word is available: in standard mode the memory is empty, in fall-through mode `out_flag_o` is low.
- R9: Master reset and partial reset both return the read and write pointers to location 0, which leaves the FIFO empty.
- R10: An edge with `rt_ni` low sets the read pointer to location 0. The memory count becomes the number of words written since the last reset, saturated at DEPTH. In fall-through mode any presented word is discarded and the replay starts from the first word.
- R11: A write in the same cycle as a retransmit is kept and is counted in the replayed data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; selects standard mode |
| mrst_i | input | 1 | Synchronous master reset; captures the mode |
| prst_i | input | 1 | Synchronous partial reset; keeps the mode |
| mode_sel_i | input | 1 | Mode strap: 0 standard, 1 fall-through |
| wen_ni | input | 1 | Write enable, active low |
| ren_ni | input | 1 | Read enable, active low |
| rt_ni | input | 1 | Retransmit, active low |
| din_i | input | DW | Write data |
| dout_o | output | DW | Read data |
| out_flag_o | output | 1 | Empty (standard) / output ready (fall-through) |
| in_flag_o | output | 1 | Full (standard) / input ready (fall-through) |
| half_o | output | 1 | Memory holds more than DEPTH/2 words |

## Verification
A retransmit and a write can land on the same edge. The count must then be rebuilt from the write total, including the new word, while the write pointer still advances. The bench drives `rt_ni` and `wen_ni` low together in fall-through mode after three words have been stored. It then checks that `in_flag_o` drops, because the recount reaches DEPTH, and that the replay presents all four words in order, the last one being the word written during the rewind.

// File: rtl/ff_pkg.sv
package ff_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/ff_mem.sv
module ff_mem #(
  parameter int DW = 16,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // registered read port doubles as the first prefetch stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/ff_ptr.sv
module ff_ptr #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          rt_i,
  input  logic          wr_req_i,
  input  logic          fetch_i,
  output logic          wr_ok_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] raddr_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          avail_o,
  output logic          half_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [CW-1:0] tot_q, tot_n;

  assign full_o  = (count_o == FULL_CNT);
  assign avail_o = (count_o != '0);
  assign half_o  = (count_o > HALF_CNT);
  assign wr_ok_o = wr_req_i && !full_o;
  assign tot_n   = (wr_ok_o && tot_q != FULL_CNT) ? tot_q + 1'b1 : tot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      waddr_o <= '0; raddr_o <= '0; count_o <= '0; tot_q <= '0;
    end else if (clr_i) begin
      waddr_o <= '0; raddr_o <= '0; count_o <= '0; tot_q <= '0;
    end else begin
      tot_q <= tot_n;
      if (wr_ok_o) waddr_o <= waddr_o + 1'b1;
      if (rt_i) begin
        raddr_o <= '0;
        count_o <= tot_n;
      end else begin
        if (fetch_i) raddr_o <= raddr_o + 1'b1;
        count_o <= count_o + CW'(wr_ok_o) - CW'(fetch_i);
      end
    end
  end

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= FULL_CNT);
  p_full_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !fetch_i && !rt_i && !clr_i) |=> (full_o && $stable(waddr_o)));
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (count_o == '0 && raddr_o == '0 && waddr_o == '0));
  p_rewind_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rt_i && !clr_i) |=> (raddr_o == '0));
endmodule

// File: rtl/ff_out.sv
module ff_out #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          flush_i,
  input  logic          avail_i,
  input  logic          ren_ni,
  input  logic [DW-1:0] rd_data_i,
  output logic          fetch_o,
  output logic [DW-1:0] dout_o,
  output logic          rdy_o
);
  logic          stg_vld_q, rdy_q;
  logic [DW-1:0] hold_q;
  logic          pop, out_free, move, stg_free;

  // fall-through: memory read register is stage 1, hold_q is the output stage
  assign pop      = rdy_q && !ren_ni;
  assign out_free = !rdy_q || pop;
  assign move     = stg_vld_q && out_free;
  assign stg_free = !stg_vld_q || move;

  always_comb begin
    if (flush_i)     fetch_o = 1'b0;
    else if (fwft_i) fetch_o = avail_i && stg_free;
    else             fetch_o = avail_i && !ren_ni;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_vld_q <= 1'b0; rdy_q <= 1'b0; hold_q <= '0;
    end else if (flush_i || !fwft_i) begin
      stg_vld_q <= 1'b0; rdy_q <= 1'b0;
    end else begin
      if (fetch_o)   stg_vld_q <= 1'b1;
      else if (move) stg_vld_q <= 1'b0;
      if (move) begin
        hold_q <= rd_data_i;
        rdy_q  <= 1'b1;
      end else if (pop) begin
        rdy_q  <= 1'b0;
      end
    end
  end

  assign dout_o = fwft_i ? hold_q : rd_data_i;
  assign rdy_o  = rdy_q;

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwft_i && rdy_q && ren_ni && !flush_i) |=> (rdy_q && $stable(hold_q)));
  p_flush_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!rdy_q && !stg_vld_q));
endmodule

// File: rtl/ff_dm_ctrl.sv
module ff_dm_ctrl #(
  parameter int DW = 16,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mrst_i,
  input  logic          prst_i,
  input  logic          mode_sel_i,
  input  logic          wen_ni,
  input  logic          ren_ni,
  input  logic          rt_ni,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  output logic          out_flag_o,
  output logic          in_flag_o,
  output logic          half_o
);
  import ff_pkg::*;

  rd_mode_e      mode_q;
  logic          clr, fwft, flush;
  logic          wr_ok, fetch, full, avail, rdy;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] count;
  logic [DW-1:0] rd_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_q <= MODE_STD;
    else if (mrst_i) mode_q <= rd_mode_e'(mode_sel_i);
  end

  assign clr   = mrst_i || prst_i;
  assign fwft  = (mode_q == MODE_FWFT);
  assign flush = clr || !rt_ni;

  ff_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i, .rst_ni, .clr_i(clr), .rt_i(!rt_ni), .wr_req_i(!wen_ni),
    .fetch_i(fetch), .wr_ok_o(wr_ok), .waddr_o(waddr), .raddr_o(raddr),
    .count_o(count), .full_o(full), .avail_o(avail), .half_o(half_o)
  );

  ff_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk_i, .rst_ni, .we_i(wr_ok), .waddr_i(waddr), .wdata_i(din_i),
    .re_i(fetch), .raddr_i(raddr), .rdata_o(rd_data)
  );

  ff_out #(.DW(DW)) u_out (
    .clk_i, .rst_ni, .fwft_i(fwft), .flush_i(flush), .avail_i(avail),
    .ren_ni, .rd_data_i(rd_data), .fetch_o(fetch), .dout_o, .rdy_o(rdy)
  );

  assign out_flag_o = fwft ? rdy : !avail;
  assign in_flag_o  = fwft ? !full : full;

  p_mode_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mrst_i |=> $stable(mode_q));
  p_mode_take_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrst_i |=> (mode_q == rd_mode_e'($past(mode_sel_i))));
  p_count_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count <= CW'(DEPTH)));
endmodule

// File: tb/ff_dm_ctrl_bench.sv
module ff_dm_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int DW = 8;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, mrst_i = 1'b0, prst_i = 1'b0, mode_sel_i = 1'b0;
  logic wen_ni = 1'b1, ren_ni = 1'b1, rt_ni = 1'b1;
  logic [DW-1:0] din_i = '0;
  logic [DW-1:0] dout_o;
  logic out_flag_o, in_flag_o, half_o;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  ff_dm_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_ff_dm_ctrl (
    .clk_i(clk), .rst_ni, .mrst_i, .prst_i, .mode_sel_i, .wen_ni, .ren_ni,
    .rt_ni, .din_i, .dout_o, .out_flag_o, .in_flag_o, .half_o
  );

  // row: wen_n, ren_n, din[8], chk_dout, exp_dout[8], exp_empty, exp_full, exp_half
  localparam int NV = 11;
  localparam logic [21:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'h11, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h22, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0},
    {1'b0, 1'b1, 8'h33, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1},
    {1'b0, 1'b1, 8'h44, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1},
    {1'b0, 1'b1, 8'h55, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1},
    {1'b1, 1'b0, 8'h00, 1'b1, 8'h11, 1'b0, 1'b0, 1'b1},
    {1'b0, 1'b0, 8'h66, 1'b1, 8'h22, 1'b0, 1'b0, 1'b1},
    {1'b1, 1'b0, 8'h00, 1'b1, 8'h33, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h00, 1'b1, 8'h44, 1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h00, 1'b1, 8'h66, 1'b1, 1'b0, 1'b0},
    {1'b1, 1'b0, 8'h00, 1'b1, 8'h66, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic idle();
    wen_ni = 1'b1; ren_ni = 1'b1; rt_ni = 1'b1; mrst_i = 1'b0; prst_i = 1'b0;
  endtask

  task automatic wr(input logic [DW-1:0] d);
    wen_ni = 1'b0; din_i = d; tick(); wen_ni = 1'b1;
  endtask

  initial begin
    #(CLK_P*5000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P*2 + 2);
    rst_ni = 1'b1;
    tick();
    chk("R3 reset empty", out_flag_o, 1);
    chk("R3 reset full", in_flag_o, 0);
    chk("R7 reset half", half_o, 0);

    // standard mode, table walk
    mrst_i = 1'b1; mode_sel_i = 1'b0; tick(); idle();
    for (int i = 0; i < NV; i++) begin
      wen_ni = VEC[i][21]; ren_ni = VEC[i][20]; din_i = VEC[i][19:12];
      tick();
      if (VEC[i][11]) chk($sformatf("R2 vec%0d dout", i), dout_o, VEC[i][10:3]);
      chk($sformatf("R3 R8 vec%0d empty", i), out_flag_o, VEC[i][2]);
      chk($sformatf("R3 R8 vec%0d full", i), in_flag_o, VEC[i][1]);
      chk($sformatf("R7 vec%0d half", i), half_o, VEC[i][0]);
    end
    idle();

    // fall-through mode
    mrst_i = 1'b1; mode_sel_i = 1'b1; tick(); idle(); mode_sel_i = 1'b0;
    chk("R1 R6 fwft not ready", out_flag_o, 0);
    chk("R6 fwft input ready", in_flag_o, 1);
    wr(8'hA1);
    chk("R4 edge1 not ready", out_flag_o, 0);
    tick();
    chk("R4 edge2 not ready", out_flag_o, 0);
    tick();
    chk("R4 edge3 ready", out_flag_o, 1);
    chk("R4 edge3 dout", dout_o, 8'hA1);
    wr(8'hA2); wr(8'hA3); tick(); tick();
    chk("R5 hold dout", dout_o, 8'hA1);
    chk("R5 hold ready", out_flag_o, 1);
    ren_ni = 1'b0;
    tick(); chk("R5 advance A2", dout_o, 8'hA2);
    tick(); chk("R5 advance A3", dout_o, 8'hA3);
    tick(); chk("R5 drained", out_flag_o, 0);
    ren_ni = 1'b1;

    // retransmit with a simultaneous write
    rt_ni = 1'b0; wen_ni = 1'b0; din_i = 8'hA4; tick(); idle();
    chk("R10 rt flush", out_flag_o, 0);
    chk("R11 rt recount full", in_flag_o, 0);
    tick(); tick();
    chk("R10 replay first", dout_o, 8'hA1);
    ren_ni = 1'b0;
    tick(); chk("R10 replay A2", dout_o, 8'hA2);
    tick(); chk("R10 replay A3", dout_o, 8'hA3);
    tick(); chk("R11 replay A4", dout_o, 8'hA4);
    ren_ni = 1'b1;

    // partial reset keeps fall-through mode
    prst_i = 1'b1; tick(); idle();
    chk("R9 prst empty", out_flag_o, 0);
    chk("R9 prst input ready", in_flag_o, 1);
    wr(8'hB1); tick(); tick();
    chk("R1 mode kept", out_flag_o, 1);
    chk("R1 mode kept dout", dout_o, 8'hB1);

    // fill memory in fall-through mode
    wr(8'hC1); wr(8'hC2); wr(8'hC3); wr(8'hC4); wr(8'hC5);
    chk("R6 not input ready", in_flag_o, 0);
    chk("R7 fwft half", half_o, 1);
    wr(8'hC6);
    chk("R8 full write dropped", in_flag_o, 0);
    ren_ni = 1'b0;
    tick(); chk("R5 read C1", dout_o, 8'hC1);
    chk("R6 input ready again", in_flag_o, 1);
    tick(); chk("R5 read C2", dout_o, 8'hC2);
    tick(); chk("R5 read C3", dout_o, 8'hC3);
    tick(); chk("R5 read C4", dout_o, 8'hC4);
    tick(); chk("R5 read C5", dout_o, 8'hC5);
    tick(); chk("R8 C6 absent", out_flag_o, 0);
    tick(); chk("R8 read on empty", out_flag_o, 0);
    ren_ni = 1'b1;

    // standard mode retransmit
    mrst_i = 1'b1; mode_sel_i = 1'b0; tick(); idle();
    chk("R9 mrst empty", out_flag_o, 1);
    wr(8'hD1); wr(8'hD2);
    ren_ni = 1'b0;
    tick(); chk("R2 std D1", dout_o, 8'hD1);
    tick(); chk("R2 std D2", dout_o, 8'hD2);
    ren_ni = 1'b1;
    chk("R3 std empty", out_flag_o, 1);
    rt_ni = 1'b0; tick(); idle();
    chk("R10 std recount", out_flag_o, 0);
    ren_ni = 1'b0; tick(); ren_ni = 1'b1;
    chk("R10 std replay", dout_o, 8'hD1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule